// File: doc/BRIEF.md
# Data Cache Maintenance Control Unit

This unit sits in front of a data cache and turns register writes from a processor into maintenance commands for the tag and data arrays. Software can discard lines, write dirty lines back to memory, or do both. It can address one line at a time or the whole cache. A sticky invalidate-mode bit in the control register decides what an invalidate command does. With the bit at 0, an invalidate is a pure discard. With the bit at 1, an invalidate writes the line back first and then discards it. A writeback-and-invalidate sequence is therefore: set the mode bit, issue the invalidate, then clear the bit again.

Every operation that includes a writeback sets a read-only drain-status bit in the control register. The bit stays set for a modelled writeback time: `WB_CYCLES` cycles for one line, or `WB_CYCLES*WHOLE_LINES` cycles for the whole cache. Software polls this bit until it reads 0. While the bit is set, `wr_ready` is low. A requester holds its write until `wr_ready` returns high, so a command that arrives during a drain waits and is never lost.

The controller has two states. `IDLE` accepts register writes. A discard-only command stays in `IDLE`. A command that writes back takes the transition `IDLE -> DRAIN`. `DRAIN` holds the status bit set and stalls writes until the drain timer expires, then takes the transition `DRAIN -> IDLE`. Reset enters `IDLE`.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: After reset the mode bit reads 0, the status bit reads 0, `wr_ready` is 1 and `arr_valid` is 0.
- R2: The register at select 0 is the control register. Bit 0 is the invalidate mode and bit 1 is the drain status. Reading it returns both bits, with all other bits 0. A write updates bit 0 from `wdata[0]`. Writes to bit 1 have no effect.
- R3: A write to select 1 (whole invalidate) with `wdata[0]=1` in mode 0 produces, one cycle later, one `arr_valid` pulse with `arr_kind`=0 (discard) and `arr_whole`=1. The status bit stays 0.
- R4: A write to select 2 (whole writeback) with `wdata[0]=1` produces one pulse with `arr_kind`=1 (writeback) and `arr_whole`=1. The status bit then reads 1 for exactly `WB_CYCLES*WHOLE_LINES` cycles.
- R5: A write to select 3 (line invalidate) in mode 0 produces one pulse with `arr_kind`=0, `arr_whole`=0 and `arr_line`=`wdata>>LINE_OFF`. The status bit stays 0.
- R6: A write to select 4 (line writeback) produces one pulse with `arr_kind`=1, `arr_whole`=0 and `arr_line`=`wdata>>LINE_OFF`. The status bit then reads 1 for exactly `WB_CYCLES` cycles.
- R7: In mode 1, invalidates use `arr_kind`=2 (writeback then discard). The status bit is then set for `WB_CYCLES*WHOLE_LINES` cycles (whole cache) or `WB_CYCLES` cycles (line).
- R8: While the status bit is 1, `wr_ready` is 0 and no write is taken. A write held through the drain is accepted in the first cycle with `wr_ready`=1.
- R9: The mode bit keeps its value across every command and changes only on a control-register write.
- R10: Writes to select 1 or 2 with `wdata[0]=0`, and writes to selects 5 to 7, produce no pulse and no drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write request, held until `wr_ready` |
| reg_sel | input | SEL_W | Register select |
| wdata | input | ADDR_W | Write data or line byte address |
| wr_ready | output | 1 | Write accepted this cycle when high |
| rdata | output | ADDR_W | Combinational read of the selected register |
| arr_valid | output | 1 | One-cycle command pulse to the arrays |
| arr_kind | output | 2 | 0 discard, 1 writeback, 2 writeback then discard |
| arr_whole | output | 1 | Command covers the whole cache |
| arr_line | output | ADDR_W-LINE_OFF | Line address of a per-line command |

## Verification
The assertions assume the requester keeps `wr_en`, `reg_sel` and `wdata` steady while `wr_ready` is low. They also assume that only the control register changes the mode. The bench drives every write through a single task. That task raises the request, holds all three inputs until it sees `wr_ready` at a falling edge, and drops the request right after the accepting edge, so the stimulus never breaks these assumptions.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    typedef enum logic [1:0] {
        OP_DISCARD    = 2'd0,
        OP_WRITEBACK  = 2'd1,
        OP_WB_DISCARD = 2'd2
    } op_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } ctl_state_e;

    localparam int SEL_CTRL      = 0;
    localparam int SEL_WHOLE_INV = 1;
    localparam int SEL_WHOLE_WB  = 2;
    localparam int SEL_LINE_INV  = 3;
    localparam int SEL_LINE_WB   = 4;
endpackage

// File: rtl/dcm_cmd_decode.sv
module dcm_cmd_decode
    import dcm_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             trig_bit,
    input  logic             inv_mode,
    output logic             is_ctrl,
    output logic             act,
    output op_kind_e         kind,
    output logic             whole,
    output logic             needs_drain
);
    always_comb begin
        is_ctrl = 1'b0;
        act     = 1'b0;
        kind    = OP_DISCARD;
        whole   = 1'b0;
        unique case (sel)
            SEL_W'(SEL_CTRL): is_ctrl = 1'b1;
            SEL_W'(SEL_WHOLE_INV): begin
                act   = trig_bit;
                kind  = inv_mode ? OP_WB_DISCARD : OP_DISCARD;
                whole = 1'b1;
            end
            SEL_W'(SEL_WHOLE_WB): begin
                act   = trig_bit;
                kind  = OP_WRITEBACK;
                whole = 1'b1;
            end
            SEL_W'(SEL_LINE_INV): begin
                act  = 1'b1;
                kind = inv_mode ? OP_WB_DISCARD : OP_DISCARD;
            end
            SEL_W'(SEL_LINE_WB): begin
                act  = 1'b1;
                kind = OP_WRITEBACK;
            end
            default: ;
        endcase
        needs_drain = act && (kind != OP_DISCARD);
    end
endmodule

// File: rtl/dcm_drain_timer.sv
module dcm_drain_timer #(
    parameter int WB_CYCLES   = 4,
    parameter int WHOLE_LINES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_whole,
    input  logic run,
    output logic done
);
    localparam int WHOLE_LEN = WB_CYCLES * WHOLE_LINES;
    localparam int CNT_W     = $clog2(WHOLE_LEN + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_whole ? CNT_W'(WHOLE_LEN - 1) : CNT_W'(WB_CYCLES - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R4 / R6: the remaining drain time never exceeds the longest drain
    assert_drain_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WHOLE_LEN - 1));

    // R8: the count only moves down while a drain runs
    assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl
    import dcm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_OFF    = 5,
    parameter int SEL_W       = 3,
    parameter int WB_CYCLES   = 4,
    parameter int WHOLE_LINES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           reg_sel,
    input  logic [ADDR_W-1:0]          wdata,
    output logic                       wr_ready,
    output logic [ADDR_W-1:0]          rdata,
    output logic                       arr_valid,
    output logic [1:0]                 arr_kind,
    output logic                       arr_whole,
    output logic [ADDR_W-LINE_OFF-1:0] arr_line
);
    localparam int LINE_W = ADDR_W - LINE_OFF;

    ctl_state_e state, state_nx;
    logic       inv_mode;
    logic       busy;
    logic       accept;
    logic       dec_ctrl, dec_act, dec_whole, dec_drain;
    op_kind_e   dec_kind;
    logic       timer_done;

    dcm_cmd_decode #(.SEL_W(SEL_W)) u_dec (
        .sel         (reg_sel),
        .trig_bit    (wdata[0]),
        .inv_mode    (inv_mode),
        .is_ctrl     (dec_ctrl),
        .act         (dec_act),
        .kind        (dec_kind),
        .whole       (dec_whole),
        .needs_drain (dec_drain)
    );

    dcm_drain_timer #(.WB_CYCLES(WB_CYCLES), .WHOLE_LINES(WHOLE_LINES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept && dec_drain),
        .load_whole (dec_whole),
        .run        (state == ST_DRAIN),
        .done       (timer_done)
    );

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept && dec_drain) state_nx = ST_DRAIN;
            ST_DRAIN: if (timer_done)          state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output process
    always_comb begin
        busy     = (state == ST_DRAIN);
        wr_ready = !busy;
        accept   = wr_en && !busy;
        rdata    = '0;
        if (dec_ctrl) rdata[1:0] = {busy, inv_mode};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_mode  <= 1'b0;
            arr_valid <= 1'b0;
            arr_kind  <= OP_DISCARD;
            arr_whole <= 1'b0;
            arr_line  <= '0;
        end else begin
            arr_valid <= accept && dec_act;
            if (accept && dec_ctrl) inv_mode <= wdata[0];
            if (accept && dec_act) begin
                arr_kind  <= dec_kind;
                arr_whole <= dec_whole;
                arr_line  <= dec_whole ? '0 : wdata[ADDR_W-1:LINE_OFF];
            end
        end
    end

    // R8: nothing is issued in the cycle after a stalled (draining) cycle
    assert_no_issue_in_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> !arr_valid);

    // R3 / R5: a discard never starts a drain
    assert_discard_no_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_kind == OP_DISCARD) |-> !busy);

    // R6 / R7: every writeback command is accompanied by a drain
    assert_wb_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_kind != OP_DISCARD) |-> busy);

    // R9: mode is sticky apart from control writes
    assert_mode_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && dec_ctrl) |=> $stable(inv_mode));

    // R8: a stalled request must be held steady
    assert_held_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> (wr_en && $stable(reg_sel) && $stable(wdata)));

    // R7: kind encoding stays within its three legal values
    assert_kind_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid |-> (arr_kind != 2'd3));
endmodule

// File: tb/dcache_maint_ctrl_test.sv
module dcache_maint_ctrl_test;
    localparam int ADDR_W = 32;
    localparam int OFF    = 5;
    localparam int WBC    = 4;
    localparam int WL     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        reg_sel = '0;
    logic [ADDR_W-1:0] wdata = '0;
    logic              wr_ready;
    logic [ADDR_W-1:0] rdata;
    logic              arr_valid;
    logic [1:0]        arr_kind;
    logic              arr_whole;
    logic [ADDR_W-OFF-1:0] arr_line;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dcache_maint_ctrl #(.ADDR_W(ADDR_W), .LINE_OFF(OFF), .SEL_W(3),
                        .WB_CYCLES(WBC), .WHOLE_LINES(WL)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
        .wr_ready(wr_ready), .rdata(rdata), .arr_valid(arr_valid), .arr_kind(arr_kind),
        .arr_whole(arr_whole), .arr_line(arr_line)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [ADDR_W-1:0] d, output int stall);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        stall = 0;
        #1;
        while (!wr_ready) begin
            stall++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // samples the command pulse, then counts drain cycles through the control register
    task automatic observe(input bit ev, input int ek, input bit ew,
                           input logic [ADDR_W-OFF-1:0] el, input int eb, input string req);
        int n;
        @(negedge clk);
        #1;
        chk(arr_valid == ev, {req, " pulse"}, arr_valid, ev);
        if (ev) begin
            chk(arr_kind == 2'(ek), {req, " kind"}, arr_kind, ek);
            chk(arr_whole == ew, {req, " whole"}, arr_whole, ew);
            if (!ew) chk(arr_line == el, {req, " line"}, arr_line, el);
        end
        reg_sel = 3'd0;
        #1;
        n = 0;
        while (rdata[1] && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
        chk(n == eb, {req, " drain"}, n, eb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int st;
        logic [ADDR_W-1:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(rdata[1:0] == 2'b00, "R1 ctrl", rdata, 0);
        chk(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
        chk(arr_valid == 1'b0, "R1 pulse", arr_valid, 0);

        // R2 status bit not writable, mode writable, upper bits zero
        do_write(3'd0, 32'hFFFF_FFFE, st);
        #1;
        chk(rdata == 32'h0, "R2 status write ignored", rdata, 0);
        do_write(3'd0, 32'h1, st);
        #1;
        chk(rdata == 32'h1, "R2 mode set", rdata, 1);

        // sweep: mode x select x trigger bit
        for (int m = 0; m < 2; m++) begin
            for (int s = 1; s < 8; s++) begin
                for (int b = 0; b < 2; b++) begin
                    bit act; int k; bit w; int bz;
                    do_write(3'd0, ADDR_W'(m), st);
                    a = 32'h4000_0000 + ADDR_W'(s * 32'h1234_560) + ADDR_W'(b);
                    act = 0; k = 0; w = 0; bz = 0;
                    case (s)
                        1: begin act = b[0]; k = m ? 2 : 0; w = 1; bz = m ? WBC*WL : 0; end // R3 R7 R10
                        2: begin act = b[0]; k = 1; w = 1; bz = WBC*WL; end                 // R4 R10
                        3: begin act = 1; k = m ? 2 : 0; bz = m ? WBC : 0; end              // R5 R7
                        4: begin act = 1; k = 1; bz = WBC; end                              // R6
                        default: ;                                                           // R10
                    endcase
                    if (!act) bz = 0;
                    do_write(3'(s), a, st);
                    observe(act, k, w, a[ADDR_W-1:OFF], bz,
                            $sformatf("R%0d sel%0d mode%0d b%0d",
                                      (m && (s == 1 || s == 3)) ? 7 : (s <= 4 ? s + 2 : 10), s, m, b));
                    reg_sel = 3'd0;
                    #1;
                    chk(rdata[0] == m[0], "R9 mode sticky", rdata[0], m);
                end
            end
        end

        // R8: command held during a drain is accepted afterwards, not dropped
        do_write(3'd0, 32'h0, st);
        do_write(3'd4, 32'h8000_1000, st);
        do_write(3'd3, 32'h8000_2040, st);
        chk(st == WBC, "R8 stall cycles", st, WBC);
        observe(1, 0, 0, 27'(32'h8000_2040 >> OFF), 0, "R8 held cmd");

        // R8: stall behind a whole-cache writeback
        do_write(3'd2, 32'h1, st);
        do_write(3'd0, 32'h1, st);
        chk(st == WBC*WL, "R8 stall whole", st, WBC*WL);
        #1;
        reg_sel = 3'd0;
        #1;
        chk(rdata[0] == 1'b1, "R8 held ctrl write", rdata[0], 1);

        // R1 reset again clears mode
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rdata[1:0] == 2'b00, "R1 reset clears mode", rdata, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule